// File: doc/BRIEF.md
# Serial Flash Access Timing Sequencer

This block sits between a host command port and the SPI master that drives a serial NOR flash. It decides when the master may start a transaction, so the flash's access-timing rules are kept without the host having to know them. After reset it refuses all commands until a power-up settling time has passed. Between two transactions it keeps the chip select idle for a minimum time. After a program or erase it keeps the port closed for the worst-case duration of that operation. It also tells the master which serial clock rate to use. The plain low-speed read opcode gets a slow clock and every other opcode gets a fast one.

The host offers a command with a valid/ready handshake. The command carries an 8-bit opcode and a 2-bit operation kind. On acceptance the sequencer raises a one-cycle start strobe to the SPI master. It also presents the opcode, a slow-clock flag and the SCK half-period in system clock cycles. The master answers with a done pulse when it releases chip select. All delays are given in physical units as parameters and are turned into cycle counts when the design is elaborated, always rounding up. A two-stage synchronizer releases the asynchronous reset, and the power-up wait is counted from that release.

Top module: `flash_timing_seq`

## Requirements
- R1: After the internal reset release (two clock edges after `rst_n` rises), `cmd_ready` stays low and `spi_start` stays low for exactly PWRUP = ceil(PWRUP_NS·f/1e9) edges. `cmd_ready` rises after the PWRUP-th counting edge.
- R2: After `spi_done` is sampled for a kind 2'b00 (plain) command, `cmd_ready` stays low for exactly GAP = ceil(CS_GAP_NS·f/1e9) edges (minimum 1).
- R3: Opcode 8'h03 drives `spi_sck_slow`=1 and `spi_sck_half` = ceil(max(SLOW_PHASE_PS, 1e12/(2·SLOW_FMAX_HZ))·f/1e12). Every other opcode drives `spi_sck_slow`=0 and the same formula with the fast limits. Both values appear together with `spi_start`.
- R4: Kind 2'b01 (byte program) keeps `cmd_ready` low for max(GAP, ceil(BYTE_PROG_NS·f/1e9)) edges after `spi_done`.
- R5: Kind 2'b10 (sector or block erase) keeps `cmd_ready` low for max(GAP, ceil(BLOCK_ERASE_NS·f/1e9)) edges after `spi_done`.
- R6: Kind 2'b11 (chip erase) keeps `cmd_ready` low for max(GAP, ceil(CHIP_ERASE_NS·f/1e9)) edges after `spi_done`.
- R7: A command is taken only on an edge where `cmd_valid` and `cmd_ready` are both high. `spi_start` is high for exactly the one cycle after that edge. `spi_opcode` and the clock selection hold the accepted values until the next acceptance.
- R8: A command offered while `cmd_ready` is low is not lost. It is taken on the first edge at which `cmd_ready` is high.
- R9: A `spi_done` pulse while no transaction is open has no effect: `cmd_ready` stays high and `busy` stays low.
- R10: Asserting `rst_n` during a program or erase wait aborts the wait. It drops `busy` and `cmd_ready` at once and restarts the full power-up wait of R1.
- R11: `busy` is high from the cycle after acceptance until `spi_done` is sampled. For kinds other than 2'b00 it also stays high for the whole wait that follows. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Sequencer can take a command this cycle |
| cmd_opcode | input | 8 | Flash opcode of the offered command |
| cmd_kind | input | 2 | Operation kind: 00 plain, 01 byte program, 10 sector/block erase, 11 chip erase |
| spi_start | output | 1 | One-cycle strobe telling the SPI master to begin |
| spi_opcode | output | 8 | Opcode of the accepted command |
| spi_sck_slow | output | 1 | High when the slow serial clock must be used |
| spi_sck_half | output | HALF_W | SCK high/low phase length in system clock cycles |
| spi_done | input | 1 | SPI master has finished and released chip select |
| busy | output | 1 | Transfer open or program/erase wait running |

## Verification
Every output is a register, so each result is due at a fixed edge. `spi_start`, the opcode and the clock selection appear one cycle after the accepting edge. The power-up wait ends PWRUP+2 edges after `rst_n` rises. After the edge that samples `spi_done`, `cmd_ready` returns W+1 negative edges later, where W is the wait for that kind. A command held through a wait produces `spi_start` at W+2. The bench keeps a behavioural model that counts edges and stores the cycle at which the port reopens. It compares all outputs with that model on every falling edge, away from the edge where they change. It also measures these intervals directly with counters.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int unsigned OPC_W            = 8;
  localparam int unsigned RST_SYNC_STAGES  = 2;
  localparam logic [OPC_W-1:0] OPC_SLOW_READ = 8'h03;

  typedef enum logic [1:0] {
    KIND_PLAIN       = 2'b00,
    KIND_BYTE_PROG   = 2'b01,
    KIND_BLOCK_ERASE = 2'b10,
    KIND_CHIP_ERASE  = 2'b11
  } op_kind_e;

  typedef enum logic [1:0] {
    SEQ_PWRUP = 2'd0,
    SEQ_IDLE  = 2'd1,
    SEQ_XFER  = 2'd2,
    SEQ_HOLD  = 2'd3
  } seq_state_e;

  function automatic longint unsigned ceil_div(longint unsigned a, longint unsigned b);
    return (a + b - 64'd1) / b;
  endfunction

  function automatic longint unsigned max2(longint unsigned a, longint unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic longint unsigned at_least_one(longint unsigned v);
    return (v == 64'd0) ? 64'd1 : v;
  endfunction

  // delay in ns -> system cycles, rounded up, never zero
  function automatic longint unsigned ns_to_cycles(longint unsigned ns, longint unsigned hz);
    return at_least_one(ceil_div(ns * hz, 64'd1_000_000_000));
  endfunction

  // SCK phase length in cycles: the longer of the minimum phase and half the period limit
  function automatic longint unsigned phase_cycles(longint unsigned min_ps,
                                                   longint unsigned fmax_hz,
                                                   longint unsigned hz);
    longint unsigned half_ps;
    half_ps = max2(min_ps, ceil_div(64'd1_000_000_000_000, 64'd2 * fmax_hz));
    return at_least_one(ceil_div(half_ps * hz, 64'd1_000_000_000_000));
  endfunction

  function automatic int unsigned width_for(longint unsigned v);
    return (v < 64'd2) ? 1 : $clog2(v + 64'd1);
  endfunction

endpackage

// File: rtl/fts_reset_sync.sv
module fts_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ni = sync_q[STAGES-1];

endmodule

// File: rtl/fts_wait_timer.sv
module fts_wait_timer #(
  parameter int unsigned      CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R2
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (expired && !load) |=> expired);

  // R4
  timer_progress_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!expired && !load) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/fts_sck_select.sv
module fts_sck_select
  import fts_pkg::*;
#(
  parameter int unsigned       HALF_W    = 8,
  parameter logic [HALF_W-1:0] SLOW_HALF = '0,
  parameter logic [HALF_W-1:0] FAST_HALF = '0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_en,
  input  logic [OPC_W-1:0]  opcode,
  output logic              sck_slow,
  output logic [HALF_W-1:0] sck_half
);

  logic              slow_d, slow_q;
  logic [HALF_W-1:0] half_d, half_q;

  always_comb begin
    slow_d = (opcode == OPC_SLOW_READ);
    half_d = slow_d ? SLOW_HALF : FAST_HALF;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= 1'b0;
      half_q <= FAST_HALF;
    end else if (load_en) begin
      slow_q <= slow_d;
      half_q <= half_d;
    end
  end

  assign sck_slow = slow_q;
  assign sck_half = half_q;

  // R7
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_en |=> ($stable(sck_half) && $stable(sck_slow)));

endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int unsigned      CNT_W     = 8,
  parameter logic [CNT_W-1:0] GAP_LD    = '0,
  parameter logic [CNT_W-1:0] PROG_LD   = '0,
  parameter logic [CNT_W-1:0] BERASE_LD = '0,
  parameter logic [CNT_W-1:0] CERASE_LD = '0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cmd_valid,
  input  logic [OPC_W-1:0] cmd_opcode,
  input  logic [1:0]       cmd_kind,
  input  logic             spi_done,
  input  logic             timer_expired,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             sck_load,
  output logic             cmd_ready,
  output logic             start,
  output logic [OPC_W-1:0] opcode,
  output logic             busy
);

  seq_state_e       state_q, state_d;
  op_kind_e         kind_q, kind_d;
  logic [OPC_W-1:0] opc_q, opc_d;
  logic             start_q, start_d;
  logic [CNT_W-1:0] hold_ld;

  // wait length after the transfer, chosen by operation kind
  always_comb begin
    case (kind_q)
      KIND_BYTE_PROG:   hold_ld = PROG_LD;
      KIND_BLOCK_ERASE: hold_ld = BERASE_LD;
      KIND_CHIP_ERASE:  hold_ld = CERASE_LD;
      default:          hold_ld = GAP_LD;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    kind_d     = kind_q;
    opc_d      = opc_q;
    start_d    = 1'b0;
    timer_load = 1'b0;
    timer_val  = hold_ld;
    case (state_q)
      SEQ_PWRUP: begin
        if (timer_expired) state_d = SEQ_IDLE;
      end
      SEQ_IDLE: begin
        if (cmd_valid) begin
          state_d = SEQ_XFER;
          start_d = 1'b1;
          opc_d   = cmd_opcode;
          kind_d  = op_kind_e'(cmd_kind);
        end
      end
      SEQ_XFER: begin
        if (spi_done) begin
          state_d    = SEQ_HOLD;
          timer_load = 1'b1;
        end
      end
      SEQ_HOLD: begin
        if (timer_expired) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_PWRUP;
      kind_q  <= KIND_PLAIN;
      opc_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      opc_q   <= opc_d;
      start_q <= start_d;
    end
  end

  assign sck_load  = start_d;
  assign cmd_ready = (state_q == SEQ_IDLE);
  assign start     = start_q;
  assign opcode    = opc_q;
  assign busy      = (state_q == SEQ_XFER) ||
                     ((state_q == SEQ_HOLD) && (kind_q != KIND_PLAIN));

  // R8
  accept_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != SEQ_IDLE) |=> !start_q);

  // R7
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_q |=> !start_q);

  // R7
  opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != SEQ_IDLE) |=> $stable(opc_q));

  // R9
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && !cmd_valid) |=> (state_q == SEQ_IDLE));

  // R1
  pwrup_wait_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SEQ_PWRUP && !timer_expired) |=> (state_q == SEQ_PWRUP));

  // R11
  busy_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_q |-> busy);

endmodule

// File: rtl/flash_timing_seq.sv
module flash_timing_seq
  import fts_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ     = 50_000_000,
  parameter int unsigned PWRUP_NS       = 100_000,
  parameter int unsigned CS_GAP_NS      = 50,
  parameter int unsigned BYTE_PROG_NS   = 10_000,
  parameter int unsigned BLOCK_ERASE_NS = 25_000_000,
  parameter int unsigned CHIP_ERASE_NS  = 50_000_000,
  parameter int unsigned SLOW_FMAX_HZ   = 33_000_000,
  parameter int unsigned FAST_FMAX_HZ   = 80_000_000,
  parameter int unsigned SLOW_PHASE_PS  = 13_000,
  parameter int unsigned FAST_PHASE_PS  = 6_000,
  parameter int unsigned HALF_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic [1:0]        cmd_kind,
  output logic              spi_start,
  output logic [7:0]        spi_opcode,
  output logic              spi_sck_slow,
  output logic [HALF_W-1:0] spi_sck_half,
  input  logic              spi_done,
  output logic              busy
);

  localparam longint unsigned PWRUP_CYC  = ns_to_cycles(PWRUP_NS, SYS_CLK_HZ);
  localparam longint unsigned GAP_CYC    = ns_to_cycles(CS_GAP_NS, SYS_CLK_HZ);
  localparam longint unsigned PROG_CYC   = max2(GAP_CYC, ns_to_cycles(BYTE_PROG_NS, SYS_CLK_HZ));
  localparam longint unsigned BERASE_CYC = max2(GAP_CYC, ns_to_cycles(BLOCK_ERASE_NS, SYS_CLK_HZ));
  localparam longint unsigned CERASE_CYC = max2(GAP_CYC, ns_to_cycles(CHIP_ERASE_NS, SYS_CLK_HZ));
  localparam longint unsigned MAX_CYC    = max2(max2(PWRUP_CYC, CERASE_CYC),
                                                max2(BERASE_CYC, PROG_CYC));
  localparam int unsigned     CNT_W      = width_for(MAX_CYC);

  localparam logic [CNT_W-1:0] PWRUP_LD  = CNT_W'(PWRUP_CYC - 64'd1);
  localparam logic [CNT_W-1:0] GAP_LD    = CNT_W'(GAP_CYC - 64'd1);
  localparam logic [CNT_W-1:0] PROG_LD   = CNT_W'(PROG_CYC - 64'd1);
  localparam logic [CNT_W-1:0] BERASE_LD = CNT_W'(BERASE_CYC - 64'd1);
  localparam logic [CNT_W-1:0] CERASE_LD = CNT_W'(CERASE_CYC - 64'd1);

  localparam logic [HALF_W-1:0] SLOW_HALF =
    HALF_W'(phase_cycles(SLOW_PHASE_PS, SLOW_FMAX_HZ, SYS_CLK_HZ));
  localparam logic [HALF_W-1:0] FAST_HALF =
    HALF_W'(phase_cycles(FAST_PHASE_PS, FAST_FMAX_HZ, SYS_CLK_HZ));

  logic             rst_ni;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_expired;
  logic             sck_load;

  fts_reset_sync #(
    .STAGES (RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  fts_wait_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PWRUP_LD)
  ) u_timer (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  fts_ctrl #(
    .CNT_W     (CNT_W),
    .GAP_LD    (GAP_LD),
    .PROG_LD   (PROG_LD),
    .BERASE_LD (BERASE_LD),
    .CERASE_LD (CERASE_LD)
  ) u_ctrl (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .cmd_valid     (cmd_valid),
    .cmd_opcode    (cmd_opcode),
    .cmd_kind      (cmd_kind),
    .spi_done      (spi_done),
    .timer_expired (timer_expired),
    .timer_load    (timer_load),
    .timer_val     (timer_val),
    .sck_load      (sck_load),
    .cmd_ready     (cmd_ready),
    .start         (spi_start),
    .opcode        (spi_opcode),
    .busy          (busy)
  );

  fts_sck_select #(
    .HALF_W    (HALF_W),
    .SLOW_HALF (SLOW_HALF),
    .FAST_HALF (FAST_HALF)
  ) u_sck_sel (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load_en  (sck_load),
    .opcode   (cmd_opcode),
    .sck_slow (spi_sck_slow),
    .sck_half (spi_sck_half)
  );

endmodule

// File: tb/flash_timing_seq_tb.sv
module flash_timing_seq_tb;

  localparam int CLK_NS      = 20;
  localparam int T_PWRUP_NS  = 2000;
  localparam int T_GAP_NS    = 50;
  localparam int T_PROG_NS   = 600;
  localparam int T_BERASE_NS = 1000;
  localparam int T_CERASE_NS = 2000;
  localparam int T_SLOWF     = 5_000_000;
  localparam int T_FASTF     = 80_000_000;
  localparam int HALF_W      = 8;

  localparam int E_PWRUP  = (T_PWRUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_GAP    = (T_GAP_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_PROG   = (T_PROG_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_BERASE = (T_BERASE_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_CERASE = (T_CERASE_NS + CLK_NS - 1) / CLK_NS;
  localparam int SLOW_LIM_NS = (1_000_000_000 + 2*T_SLOWF - 1) / (2*T_SLOWF);
  localparam int FAST_LIM_NS = (1_000_000_000 + 2*T_FASTF - 1) / (2*T_FASTF);
  localparam int E_SLOW_HALF = (((SLOW_LIM_NS > 13) ? SLOW_LIM_NS : 13) + CLK_NS - 1) / CLK_NS;
  localparam int E_FAST_HALF = (((FAST_LIM_NS > 6) ? FAST_LIM_NS : 6) + CLK_NS - 1) / CLK_NS;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [7:0]        cmd_opcode;
  logic [1:0]        cmd_kind;
  logic              spi_start;
  logic [7:0]        spi_opcode;
  logic              spi_sck_slow;
  logic [HALF_W-1:0] spi_sck_half;
  logic              spi_done;
  logic              busy;

  int n_chk  = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #(CLK_NS/2) clk = ~clk;

  flash_timing_seq #(
    .SYS_CLK_HZ     (50_000_000),
    .PWRUP_NS       (T_PWRUP_NS),
    .CS_GAP_NS      (T_GAP_NS),
    .BYTE_PROG_NS   (T_PROG_NS),
    .BLOCK_ERASE_NS (T_BERASE_NS),
    .CHIP_ERASE_NS  (T_CERASE_NS),
    .SLOW_FMAX_HZ   (T_SLOWF),
    .FAST_FMAX_HZ   (T_FASTF),
    .SLOW_PHASE_PS  (13_000),
    .FAST_PHASE_PS  (6_000),
    .HALF_W         (HALF_W)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_opcode   (cmd_opcode),
    .cmd_kind     (cmd_kind),
    .spi_start    (spi_start),
    .spi_opcode   (spi_opcode),
    .spi_sck_slow (spi_sck_slow),
    .spi_sck_half (spi_sck_half),
    .spi_done     (spi_done),
    .busy         (busy)
  );

  function automatic int wait_for(input int kind);
    case (kind)
      1: return (E_PROG > E_GAP) ? E_PROG : E_GAP;
      2: return (E_BERASE > E_GAP) ? E_BERASE : E_GAP;
      3: return (E_CERASE > E_GAP) ? E_CERASE : E_GAP;
      default: return E_GAP;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: edge counter plus the edge at which the port reopens
  int         m_cyc, m_ready_at, m_rel, m_kind;
  bit         m_xfer, m_start, m_timed, m_have_op, m_rdy;
  logic [7:0] m_op;

  task automatic m_clear();
    m_cyc = 0; m_ready_at = E_PWRUP; m_xfer = 0; m_start = 0;
    m_timed = 0; m_have_op = 0; m_op = 8'h00; m_kind = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0;
      m_clear();
    end else if (m_rel < 2) begin
      m_rel++;
      m_clear();
    end else begin
      m_rdy   = !m_xfer && (m_cyc >= m_ready_at);
      m_start = 0;
      if (m_rdy && cmd_valid) begin
        m_xfer = 1; m_start = 1; m_op = cmd_opcode; m_kind = int'(cmd_kind); m_have_op = 1;
      end else if (m_xfer && spi_done) begin
        m_xfer = 0;
        m_ready_at = m_cyc + 1 + wait_for(m_kind);
        m_timed = (m_kind != 0);
      end
      m_cyc++;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_rdy, e_busy;
      e_rdy  = !m_xfer && (m_cyc >= m_ready_at);
      e_busy = m_xfer || (m_timed && (m_cyc < m_ready_at));
      check(cur_req, "model cmd_ready", int'(cmd_ready), int'(e_rdy));
      check(cur_req, "model spi_start", int'(spi_start), int'(m_start));
      check("R11", "model busy", int'(busy), int'(e_busy));
      if (m_have_op) begin
        check("R7", "model spi_opcode", int'(spi_opcode), int'(m_op));
        check("R3", "model spi_sck_slow", int'(spi_sck_slow), int'(m_op == 8'h03));
        check("R3", "model spi_sck_half", int'(spi_sck_half),
              (m_op == 8'h03) ? E_SLOW_HALF : E_FAST_HALF);
      end
    end
  end

  // offer a command, play the SPI master, return negedges until ready again
  task automatic issue(input logic [7:0] op, input logic [1:0] kind, input int xfer,
                       output int gap, output int got_slow, output int got_half);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_kind = kind;
    do @(negedge clk); while (!spi_start);
    got_slow = int'(spi_sck_slow);
    got_half = int'(spi_sck_half);
    cmd_valid = 1'b0;
    repeat (xfer) @(negedge clk);
    spi_done = 1'b1;
    gap = 0;
    do begin
      @(negedge clk);
      spi_done = 1'b0;
      gap++;
    end while (!cmd_ready);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, gap, gs, gh;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_opcode = 8'h00; cmd_kind = 2'b00; spi_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset cmd_ready", int'(cmd_ready), 0);
    check("R1", "reset spi_start", int'(spi_start), 0);
    check("R11", "reset busy", int'(busy), 0);

    // R8: command held across the power-up wait
    cur_req = "R1";
    cmd_valid = 1'b1; cmd_opcode = 8'h03; cmd_kind = 2'b00;
    #1 rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cmd_ready);
    check("R1", "power-up edges to ready", n, E_PWRUP + 2);
    @(negedge clk);
    check("R8", "held command started", int'(spi_start), 1);
    check("R3", "slow read sck_slow", int'(spi_sck_slow), 1);
    check("R3", "slow read sck_half", int'(spi_sck_half), E_SLOW_HALF);
    cmd_valid = 1'b0;
    cur_req = "R2";
    repeat (4) @(negedge clk);
    spi_done = 1'b1;
    gap = 0;
    do begin @(negedge clk); spi_done = 1'b0; gap++; end while (!cmd_ready);
    check("R2", "plain gap", gap, E_GAP + 1);

    cur_req = "R3";
    issue(8'h0B, 2'b00, 5, gap, gs, gh);
    check("R3", "fast read sck_slow", gs, 0);
    check("R3", "fast read sck_half", gh, E_FAST_HALF);
    check("R2", "fast read gap", gap, E_GAP + 1);

    cur_req = "R4";
    issue(8'h02, 2'b01, 3, gap, gs, gh);
    check("R4", "byte program wait", gap, wait_for(1) + 1);

    cur_req = "R5";
    issue(8'h20, 2'b10, 3, gap, gs, gh);
    check("R5", "sector erase wait", gap, wait_for(2) + 1);
    issue(8'hD8, 2'b10, 2, gap, gs, gh);
    check("R5", "block erase wait", gap, wait_for(2) + 1);

    cur_req = "R6";
    issue(8'hC7, 2'b11, 1, gap, gs, gh);
    check("R6", "chip erase wait", gap, wait_for(3) + 1);
    check("R7", "opcode held after transaction", int'(spi_opcode), 8'hC7);

    // R9 stray done while idle
    cur_req = "R9";
    spi_done = 1'b1;
    @(negedge clk);
    spi_done = 1'b0;
    check("R9", "ready after stray done", int'(cmd_ready), 1);
    check("R9", "busy after stray done", int'(busy), 0);
    @(negedge clk);
    check("R9", "no start after stray done", int'(spi_start), 0);

    // R8 command offered during the chip-select gap
    cur_req = "R8";
    cmd_valid = 1'b1; cmd_opcode = 8'h05; cmd_kind = 2'b00;
    do @(negedge clk); while (!spi_start);
    repeat (2) @(negedge clk);
    spi_done = 1'b1; cmd_opcode = 8'h9F;
    n = 0;
    do begin @(negedge clk); spi_done = 1'b0; n++; end while (!spi_start);
    cmd_valid = 1'b0;
    check("R8", "edges to start of queued command", n, E_GAP + 2);
    check("R7", "queued opcode", int'(spi_opcode), 8'h9F);
    @(negedge clk);
    check("R7", "start lasts one cycle", int'(spi_start), 0);
    spi_done = 1'b1;
    do begin @(negedge clk); spi_done = 1'b0; end while (!cmd_ready);

    // R10 reset during a chip erase wait
    cur_req = "R10";
    cmd_valid = 1'b1; cmd_opcode = 8'hC7; cmd_kind = 2'b11;
    do @(negedge clk); while (!spi_start);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    spi_done = 1'b1;
    @(negedge clk);
    spi_done = 1'b0;
    repeat (10) @(negedge clk);
    check("R11", "busy during erase wait", int'(busy), 1);
    check("R6", "ready low during erase wait", int'(cmd_ready), 0);
    #1 rst_n = 1'b0;
    #2;
    check("R10", "busy dropped by reset", int'(busy), 0);
    check("R10", "ready low in reset", int'(cmd_ready), 0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cmd_ready);
    check("R10", "power-up restarted", n, E_PWRUP + 2);
    check("R10", "busy after restart", int'(busy), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule